// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides whether a small microcontroller is running, lightly asleep or deeply asleep, and it drives the clock-enable signals for the CPU, the two on-chip buses, the memory and every gated peripheral. The CPU reports that it wants to sleep with a one-cycle strobe. One strobe means "wait for interrupt" and the other means "wait for event". A depth bit, sampled together with the strobe, chooses between light sleep and deep sleep. In light sleep the CPU clock stops while the buses, the memory and the peripherals keep their clocks. In deep sleep every one of those clocks stops.

The strobe also fixes which wake source ends the sleep episode. After a wait-for-interrupt the episode ends when any interrupt becomes pending. After a wait-for-event it ends when the wakeup-event input is asserted. On wake, memory and bus clocks come back one cycle before the CPU clock, so the CPU resumes with its bus already running. In run mode each peripheral clock follows its own gate-enable input.

All enable outputs are registered on the falling clock edge. A downstream clock gate therefore sees a stable enable for the whole high phase, and no clipped pulse can occur.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, mode_o reads 00 (run), and the CPU, AHB, APB, memory and peripheral enables are all 1.
- R2: In run mode, a wfi_i or wfe_i strobe with deep_req_i=0 makes mode_o read 01 (sleep) from the next rising edge. In that mode the CPU enable is 0 and the AHB, APB and memory enables are 1.
- R3: In run mode, a wfi_i or wfe_i strobe with deep_req_i=1 makes mode_o read 10 (deep sleep). In that mode the CPU, AHB, APB and memory enables are all 0.
- R4: A sleep episode entered through wfi_i ends at the first rising edge where any bit of irq_pend_i is 1. In such an episode wake_evt_i has no effect.
- R5: A sleep episode entered through wfe_i ends at the first rising edge where wake_evt_i is 1. In such an episode irq_pend_i has no effect.
- R6: mode_o never reads 11. The only states are run, sleep and deep sleep.
- R7: In run mode with the CPU clock on, periph_clk_en_o[i] equals gate_en_i[i]. The bit order is: 0 ADC, 1–2 SSP0/SSP1, 3–4 UART0/UART1, 5–6 timer0/timer1, 7–14 PWM0–PWM7, 15 watchdog, 16 RNG.
- R8: In sleep mode all peripheral enables are 1, and in deep sleep mode they are all 0, whatever gate_en_i holds.
- R9: deep_req_i is sampled only on the entry edge. Changing it during a sleep episode changes neither the mode nor the enables.
- R10: At the wake edge, mode_o returns to 00 and the bus and memory enables turn on, while the CPU enable stays 0 for exactly one more cycle. Entry strobes in that cycle are ignored.
- R11: Enable outputs change only on falling clock edges. Just after a rising edge they still hold the values they had before it.
- R12: When wfi_i and wfe_i are strobed together, the episode uses the wait-for-interrupt wake rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_req_i | input | 1 | Sleep depth select, sampled with the entry strobe |
| wfi_i | input | 1 | Wait-for-interrupt entry strobe |
| wfe_i | input | 1 | Wait-for-event entry strobe |
| irq_pend_i | input | NUM_IRQ | Pending interrupt vector |
| wake_evt_i | input | 1 | Wakeup event |
| gate_en_i | input | NUM_PERIPH | Per-peripheral clock gate requests |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| ahb_clk_en_o | output | 1 | AHB bus clock enable |
| apb_clk_en_o | output | 1 | APB bus clock enable |
| mem_clk_en_o | output | 1 | Memory clock enable |
| periph_clk_en_o | output | NUM_PERIPH | Peripheral clock enables |
| mode_o | output | 2 | Current mode: 00 run, 01 sleep, 10 deep sleep |

## Verification
Each kind of internal fault shows up at the ports within one cycle.
- A wrong mode register shows on mode_o at once. At the next falling edge it also shows as a wrong combination of domain enables.
- A wrongly latched wake source shows as an episode that ends on the wrong stimulus, or never ends. The bench applies interrupt noise during event-based sleep and event noise during interrupt-based sleep, so this fault is exposed.
- A missing or doubled hold cycle shows as the CPU enable rising in the same cycle as the bus enables, or one cycle late.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_DEEP  = 2'b10
    } lpm_mode_e;

    typedef struct packed {
        lpm_mode_e mode;
        logic      wfe_src;   // episode entered through wait-for-event
        logic      cpu_hold;  // one-cycle CPU delay after wake
    } lpm_state_t;

    typedef struct packed {
        logic cpu;
        logic ahb;
        logic apb;
        logic mem;
    } dom_en_t;

endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel #(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] irq_pend_i,
    input  logic               wake_evt_i,
    input  logic               wfe_src_i,
    output logic               wake_o
);
    logic any_irq;

    always_comb begin
        any_irq = |irq_pend_i;
        wake_o  = wfe_src_i ? wake_evt_i : any_irq;
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wfi_i,
    input  logic      wfe_i,
    input  logic      deep_req_i,
    input  logic      wake_i,
    output lpm_mode_e mode_o,
    output logic      wfe_src_o,
    output logic      cpu_hold_o
);
    lpm_state_t st_d, st_q;
    logic       entry;

    always_comb begin
        st_d  = st_q;
        entry = (wfi_i || wfe_i) && !st_q.cpu_hold;
        case (st_q.mode)
            MODE_RUN: begin
                if (st_q.cpu_hold) begin
                    st_d.cpu_hold = 1'b0;
                end else if (entry) begin
                    st_d.mode    = deep_req_i ? MODE_DEEP : MODE_SLEEP;
                    st_d.wfe_src = !wfi_i;
                end
            end
            MODE_SLEEP, MODE_DEEP: begin
                if (wake_i) begin
                    st_d.mode     = MODE_RUN;
                    st_d.cpu_hold = 1'b1;
                end
            end
            default: begin
                st_d.mode     = MODE_RUN;
                st_d.cpu_hold = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RUN, wfe_src: 1'b0, cpu_hold: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o     = st_q.mode;
    assign wfe_src_o  = st_q.wfe_src;
    assign cpu_hold_o = st_q.cpu_hold;

    // R10: the hold lasts exactly one cycle
    p_hold_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cpu_hold |=> !st_q.cpu_hold);

    // R9: without a wake, a sleep state is kept whatever deep_req_i does
    p_stay_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_RUN && !wake_i) |=> $stable(st_q.mode));

    // R10: a wake always passes through the hold cycle
    p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_RUN && wake_i) |=> (st_q.mode == MODE_RUN && st_q.cpu_hold));

endmodule

// File: rtl/lpm_en_regs.sv
module lpm_en_regs
    import lpm_pkg::*;
#(
    parameter int NUM_PERIPH = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  lpm_mode_e             mode_i,
    input  logic                  cpu_hold_i,
    input  logic [NUM_PERIPH-1:0] gate_en_i,
    output dom_en_t               dom_en_o,
    output logic [NUM_PERIPH-1:0] periph_en_o
);
    dom_en_t               dom_d, dom_q;
    logic [NUM_PERIPH-1:0] per_d;

    always_comb begin
        case (mode_i)
            MODE_RUN: begin
                dom_d = '{cpu: !cpu_hold_i, ahb: 1'b1, apb: 1'b1, mem: 1'b1};
                per_d = gate_en_i;
            end
            MODE_SLEEP: begin
                dom_d = '{cpu: 1'b0, ahb: 1'b1, apb: 1'b1, mem: 1'b1};
                per_d = '1;
            end
            default: begin
                dom_d = '{cpu: 1'b0, ahb: 1'b0, apb: 1'b0, mem: 1'b0};
                per_d = '0;
            end
        endcase
    end

    // falling-edge registers keep each enable stable across the high phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_q <= '{cpu: 1'b1, ahb: 1'b1, apb: 1'b1, mem: 1'b1};
        end else begin
            dom_q <= dom_d;
        end
    end

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_per
        logic en_q;
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q <= 1'b1;
            end else begin
                en_q <= per_d[g];
            end
        end
        assign periph_en_o[g] = en_q;
    end

    assign dom_en_o = dom_q;

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_IRQ    = 32,
    parameter int NUM_PERIPH = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  deep_req_i,
    input  logic                  wfi_i,
    input  logic                  wfe_i,
    input  logic [NUM_IRQ-1:0]    irq_pend_i,
    input  logic                  wake_evt_i,
    input  logic [NUM_PERIPH-1:0] gate_en_i,
    output logic                  cpu_clk_en_o,
    output logic                  ahb_clk_en_o,
    output logic                  apb_clk_en_o,
    output logic                  mem_clk_en_o,
    output logic [NUM_PERIPH-1:0] periph_clk_en_o,
    output logic [1:0]            mode_o
);
    lpm_mode_e mode;
    logic      wfe_src;
    logic      cpu_hold;
    logic      wake;
    dom_en_t   dom_en;

    lpm_wake_sel #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .irq_pend_i (irq_pend_i),
        .wake_evt_i (wake_evt_i),
        .wfe_src_i  (wfe_src),
        .wake_o     (wake)
    );

    lpm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_i      (wfi_i),
        .wfe_i      (wfe_i),
        .deep_req_i (deep_req_i),
        .wake_i     (wake),
        .mode_o     (mode),
        .wfe_src_o  (wfe_src),
        .cpu_hold_o (cpu_hold)
    );

    lpm_en_regs #(.NUM_PERIPH(NUM_PERIPH)) u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .cpu_hold_i  (cpu_hold),
        .gate_en_i   (gate_en_i),
        .dom_en_o    (dom_en),
        .periph_en_o (periph_clk_en_o)
    );

    assign cpu_clk_en_o = dom_en.cpu;
    assign ahb_clk_en_o = dom_en.ahb;
    assign apb_clk_en_o = dom_en.apb;
    assign mem_clk_en_o = dom_en.mem;
    assign mode_o       = mode;

    // R6: the unused encoding never appears
    p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

    // R2, R8: light sleep shows CPU off, everything else on
    p_sleep_domains_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> (!cpu_clk_en_o && ahb_clk_en_o && apb_clk_en_o
                               && mem_clk_en_o && (&periph_clk_en_o)));

    // R3, R8: deep sleep shows every enable off
    p_deep_domains_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> (!cpu_clk_en_o && !ahb_clk_en_o && !apb_clk_en_o
                               && !mem_clk_en_o && (periph_clk_en_o == '0)));

    // R10: CPU clock returns only after buses and memory were already on
    p_wake_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en_o) |-> ($past(ahb_clk_en_o) && $past(apb_clk_en_o)
                                 && $past(mem_clk_en_o)));

endmodule

// File: tb/lpm_clk_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_tb;
    localparam int PERIOD = 10;
    localparam int NI = 32;
    localparam int NP = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          deep_req = 1'b0, wfi = 1'b0, wfe = 1'b0, evt = 1'b0;
    logic [NI-1:0] irq = '0;
    logic [NP-1:0] gate = '1;
    logic          cpu_en, ahb_en, apb_en, mem_en;
    logic [NP-1:0] per_en;
    logic [1:0]    mode;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    logic [1:0] m_mode = 2'b00;
    logic       m_wfe = 1'b0;
    logic       m_hold = 1'b0;
    logic [3+NP:0] last_en;

    always #(PERIOD/2) clk = ~clk;

    lpm_clk_ctrl #(.NUM_IRQ(NI), .NUM_PERIPH(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .deep_req_i(deep_req), .wfi_i(wfi), .wfe_i(wfe),
        .irq_pend_i(irq), .wake_evt_i(evt), .gate_en_i(gate),
        .cpu_clk_en_o(cpu_en), .ahb_clk_en_o(ahb_en), .apb_clk_en_o(apb_en),
        .mem_clk_en_o(mem_en), .periph_clk_en_o(per_en), .mode_o(mode)
    );

    function automatic logic [3+NP:0] exp_en(logic [1:0] md, logic hold, logic [NP-1:0] g);
        case (md)
            2'b00:   return {!hold, 3'b111, g};
            2'b01:   return {4'b0111, {NP{1'b1}}};
            default: return {4'b0000, {NP{1'b0}}};
        endcase
    endfunction

    function automatic string auto_tag();
        if (m_hold) return "R10";
        if (m_mode == 2'b01) return "R2";
        if (m_mode == 2'b10) return "R3";
        return "R7";
    endfunction

    task automatic check_vec(string tag);
        logic [3+NP:0] got, exp;
        got = {cpu_en, ahb_en, apb_en, mem_en, per_en};
        exp = exp_en(m_mode, m_hold, gate);
        vectors++;
        if (got !== exp || mode !== m_mode) begin
            fails++;
            $display("FAIL %s: mode=%b en=%h expected mode=%b en=%h", tag, mode, got, m_mode, exp);
        end
        last_en = got;
    endtask

    // one cycle: inputs are already driven; model steps at the rising edge
    task automatic step(string tag);
        logic wake;
        @(posedge clk);
        wake = m_wfe ? evt : (|irq);
        if (m_mode == 2'b00) begin
            if (m_hold) m_hold = 1'b0;
            else if (wfi || wfe) begin
                m_mode = deep_req ? 2'b10 : 2'b01;
                m_wfe  = !wfi;  // R12: WFI takes priority
            end
        end else if (wake) begin
            m_mode = 2'b00;
            m_hold = 1'b1;
        end
        #1;
        vectors++;  // R11: enables untouched by the rising edge
        if ({cpu_en, ahb_en, apb_en, mem_en, per_en} !== last_en) begin
            fails++;
            $display("FAIL R11: en=%h expected %h", {cpu_en, ahb_en, apb_en, mem_en, per_en}, last_en);
        end
        @(negedge clk); #1;
        check_vec(tag == "" ? auto_tag() : tag);
    endtask

    task automatic drive(logic a_wfi, logic a_wfe, logic a_deep, logic [NI-1:0] a_irq,
                         logic a_evt, logic [NP-1:0] a_gate);
        wfi = a_wfi; wfe = a_wfe; deep_req = a_deep; irq = a_irq; evt = a_evt; gate = a_gate;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'h5eed_1a2b);
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        vectors++;
        if ({mode, cpu_en, ahb_en, apb_en, mem_en, per_en} !== {2'b00, 4'hf, {NP{1'b1}}}) begin
            fails++;
            $display("FAIL R1: mode=%b en=%h expected 00/all ones", mode, {cpu_en, ahb_en, apb_en, mem_en, per_en});
        end
        last_en = {4'hf, {NP{1'b1}}};
        rst_n = 1'b1;
        drive(0, 0, 0, '0, 0, 17'h0a5a5);
        step("R1");
        step("R7");

        // R2/R4: WFI light sleep, event noise ignored, interrupt wakes
        drive(1, 0, 0, '0, 0, 17'h00f0f); step("R2");
        drive(0, 0, 1, '0, 1, 17'h00000); step("R4");
        step("R4");
        drive(0, 0, 0, 32'h0000_8000, 0, 17'h1ffff); step("R10");
        drive(1, 1, 0, '0, 0, 17'h12345); step("R10"); // strobe ignored in hold
        drive(0, 0, 0, '0, 0, 17'h12345); step("R7");

        // R3/R5/R9: WFE deep sleep, interrupt noise ignored, depth change ignored
        drive(0, 1, 1, '0, 0, 17'h1ffff); step("R3");
        drive(0, 0, 0, 32'hffff_ffff, 0, 17'h1ffff); step("R5");
        drive(0, 0, 0, 32'h1, 0, 17'h00001); step("R9");
        drive(0, 0, 0, '0, 1, 17'h00003); step("R5");
        drive(0, 0, 0, '0, 0, 17'h00003); step("R10");

        // R12: both strobes together -> interrupt wake rule
        drive(1, 1, 0, '0, 0, 17'h0); step("R12");
        drive(0, 0, 0, '0, 1, 17'h0); step("R12");
        drive(0, 0, 0, 32'h4000_0000, 0, 17'h0); step("R12");
        drive(0, 0, 0, '0, 0, 17'h0); step("R12");
        vectors++;
        if (mode === 2'b11) begin
            fails++;
            $display("FAIL R6: mode=%b expected not 11", mode);
        end

        // R8: sleep overrides gates
        drive(0, 1, 0, '0, 0, 17'h0); step("R8");
        drive(0, 0, 0, '0, 0, 17'h0); step("R8");
        drive(0, 0, 0, '0, 1, 17'h0); step("R10");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic s_wfi, s_wfe, s_evt;
            logic [NI-1:0] s_irq;
            s_wfi = ($urandom % 8) == 0;
            s_wfe = ($urandom % 8) == 0;
            s_evt = ($urandom % 10) == 0;
            s_irq = (($urandom % 16) == 0) ? (NI'(1) << ($urandom % NI)) : '0;
            drive(s_wfi, s_wfe, $urandom % 2, s_irq, s_evt, NP'($urandom));
            step("");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule